// File: doc/BRIEF.md
# Four-Channel Serial Codec Control Port

This block is the control side of a four-channel voice codec. A host drives it over a slow serial link made of a serial clock, an active-low chip select and one data-in line. Each frame is eight bits and arrives most significant bit first. The first bit of a frame gives its kind. A leading 1 makes the frame a configuration byte. A leading 0 makes it a data byte, and the data byte goes to the register that the last configuration byte selected. Configuration bits 3:2 name the channel. Bits 6:4 choose the target: a time-slot register (bit 6 = 0), a line-interface control register (101) or a gain coefficient register (100). For gain, configuration bit 0 chooses between the high half (1) and the low half (0). The per-channel registers are brought out as parallel ports for the codec datapath.

Every line-interface status byte holds five status bits above three zero bits. A status byte can reach the host in two ways. The first is during the data frame that follows a line-interface configuration: the byte is shifted out while the control byte is shifted in. The second is a command-driven burst. The byte 0xFE arms the burst mode and 0xFD disarms it. While the mode is armed and a line-interface configuration is in force, the byte 0xFF starts a burst. The burst repeats the selected channel's status byte until chip select rises. Data-out has an enable, so the host can join data-in and data-out on one wire. All inputs are sampled by a synchronous system clock, which keeps the block in one clock domain.

Top module: `scp_ctrl_port`

## Requirements
- R1: After reset all time-slot, control and gain registers read 0, and the data-out enable is low.
- R2: A configuration byte with bit 7 = 1 and bit 6 = 0, followed by a data byte with bit 7 = 0, writes data bits 6:0 into the time-slot register of channel = configuration bits 3:2.
- R3: A configuration byte with bits 7:4 = 1101 arms a simultaneous read. The following data byte writes bits 6:0 into that channel's control register. During that data frame the enable is high while chip select is low, and data-out presents {status[4:0], 000} of that channel MSB first, each bit changing on the serial-clock falling edge. This mode is not used while burst mode is armed.
- R4: A configuration byte with bits 7:4 = 1100 selects gain. With configuration bit 0 = 1 the data bits 6:0 go to the channel's high gain register, and with bit 0 = 0 they go to the low gain register. The other half is not changed.
- R5: A data byte is ignored when no configuration byte has come since the previous data byte, and also when the configuration bits 6:5 are 11. One configuration byte serves exactly one data byte.
- R6: Chip select rising before eight bits have arrived discards the partial frame, and the next frame starts from bit 7.
- R7: The bytes 0xFE, 0xFD and 0xFF are commands and never change the stored configuration. 0xFF has no effect unless burst mode is armed.
- R8: After 0xFE, with a line-interface configuration in force, 0xFF makes data-out repeat {status[4:0], 000} of the configured channel, changing on serial-clock rising edges, until chip select rises. No register is written during the burst. After 0xFD, 0xFF starts no burst.
- R9: The data-out enable is low whenever chip select is high and outside the two read procedures.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock from host |
| cs_n | input | 1 | Active-low chip select |
| din | input | 1 | Serial data in, MSB first |
| slic_status | input | 20 | Five status bits per channel, channel 0 in the low bits |
| dout | output | 1 | Serial data out |
| dout_oe | output | 1 | Drive enable for dout |
| time_slot | output | 28 | Seven-bit time-slot register per channel |
| slic_ctrl | output | 28 | Seven-bit line-interface control register per channel |
| gain_msb | output | 28 | Seven-bit high gain coefficient per channel |
| gain_lsb | output | 28 | Seven-bit low gain coefficient per channel |

## Verification
The assertions check four things on every cycle. Command bytes leave the configuration untouched. The enable drops once chip select has gone high. At most one register group changes in any cycle, and the two gain halves never change together. Register contents change only right after a completed frame. Only the bench scenarios show the rest: that a write reaches the right channel and field, the bit order and edge timing of both readout procedures, that partial frames and unconfigured data bytes are dropped, and that arming and disarming actually start or stop a burst.

// File: rtl/scp_pkg.sv
package scp_pkg;
  localparam logic [7:0] CMD_ARM    = 8'hFE;
  localparam logic [7:0] CMD_BURST  = 8'hFF;
  localparam logic [7:0] CMD_DISARM = 8'hFD;

  typedef enum logic [1:0] {M_CODEC, M_SLIC, M_GAIN, M_RSVD} mode_t;

  function automatic mode_t cfg_mode(input logic [6:0] c);
    if (!c[6])     return M_CODEC;
    else if (c[5]) return M_RSVD;
    else if (c[4]) return M_SLIC;
    else           return M_GAIN;
  endfunction
endpackage

// File: rtl/scp_sync.sv
module scp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk,
  input  logic cs_n,
  input  logic din,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_low,
  output logic cs_rise,
  output logic din_s
);
  logic [STAGES-1:0] sck_q, cs_q, din_q;
  logic              sck_d, cs_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q <= '0;
      cs_q  <= '1;
      din_q <= '0;
      sck_d <= 1'b0;
      cs_d  <= 1'b1;
    end else begin
      sck_q <= {sck_q[STAGES-2:0], sclk};
      cs_q  <= {cs_q[STAGES-2:0], cs_n};
      din_q <= {din_q[STAGES-2:0], din};
      sck_d <= sck_q[STAGES-1];
      cs_d  <= cs_q[STAGES-1];
    end
  end

  assign sck_rise = sck_q[STAGES-1] & ~sck_d;
  assign sck_fall = ~sck_q[STAGES-1] & sck_d;
  assign cs_low   = ~cs_q[STAGES-1];
  assign cs_rise  = cs_q[STAGES-1] & ~cs_d;
  assign din_s    = din_q[STAGES-1];
endmodule

// File: rtl/scp_shifter.sv
module scp_shifter #(
  parameter int FW = 8,
  localparam int CW = $clog2(FW + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sck_rise,
  input  logic          cs_low,
  input  logic          din_s,
  output logic          frame_valid,
  output logic [FW-1:0] frame,
  output logic          mid_frame
);
  logic [CW-1:0] cnt;
  logic [FW-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst || !cs_low) begin
      cnt         <= '0;
      frame_valid <= 1'b0;
    end else begin
      frame_valid <= 1'b0;
      if (sck_rise) begin
        if (cnt == CW'(FW - 1)) begin
          cnt         <= '0;
          frame_valid <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sr    <= '0;
      frame <= '0;
    end else if (cs_low && sck_rise) begin
      sr <= {sr[FW-2:0], din_s};
      if (cnt == CW'(FW - 1)) frame <= {sr[FW-2:0], din_s};
    end
  end

  assign mid_frame = (cnt != '0);
endmodule

// File: rtl/scp_readout.sv
module scp_readout #(
  parameter int FW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [FW-1:0] load_val,
  input  logic          shift,
  output logic          dout
);
  logic [FW-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst)        sr <= '0;
    else if (load)  sr <= load_val;
    else if (shift) sr <= {sr[FW-2:0], sr[FW-1]};
  end

  assign dout = sr[FW-1];
endmodule

// File: rtl/scp_regs.sv
module scp_regs
  import scp_pkg::*;
#(
  parameter int CH_W   = 2,
  parameter int DATA_W = 7,
  parameter int STAT_W = 5,
  localparam int CH    = 1 << CH_W,
  localparam int FW    = DATA_W + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 frame_valid,
  input  logic [FW-1:0]        frame,
  input  logic                 sck_rise,
  input  logic                 sck_fall,
  input  logic                 mid_frame,
  input  logic                 cs_low,
  input  logic                 cs_rise,
  input  logic [CH*STAT_W-1:0] status,
  output logic                 ro_load,
  output logic [FW-1:0]        ro_val,
  output logic                 ro_shift,
  output logic                 dout_oe,
  output logic [DATA_W-1:0]    cfg_o,
  output logic [CH*DATA_W-1:0] ts_o,
  output logic [CH*DATA_W-1:0] slic_o,
  output logic [CH*DATA_W-1:0] gmsb_o,
  output logic [CH*DATA_W-1:0] glsb_o
);
  logic [DATA_W-1:0] cfg;
  logic              cfg_valid, armed, burst, rd_active;
  logic [DATA_W-1:0] ts_m   [CH];
  logic [DATA_W-1:0] slic_m [CH];
  logic [DATA_W-1:0] gm_m   [CH];
  logic [DATA_W-1:0] gl_m   [CH];

  logic [CH_W-1:0] ch_new, ch_cfg;
  logic            is_cmd, take;
  mode_t           new_mode, cur_mode;

  assign ch_new   = frame[2 +: CH_W];
  assign ch_cfg   = cfg[2 +: CH_W];
  assign new_mode = cfg_mode(frame[DATA_W-1:0]);
  assign cur_mode = cfg_mode(cfg);
  assign is_cmd   = (frame == CMD_ARM) || (frame == CMD_BURST) || (frame == CMD_DISARM);
  assign take     = frame_valid && !burst;

  function automatic logic [FW-1:0] stat_byte(input logic [CH_W-1:0] ch);
    return {status[ch*STAT_W +: STAT_W], {(FW-STAT_W){1'b0}}};
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg       <= '0;
      cfg_valid <= 1'b0;
      armed     <= 1'b0;
      burst     <= 1'b0;
      rd_active <= 1'b0;
      ro_load   <= 1'b0;
      ro_val    <= '0;
      dout_oe   <= 1'b0;
    end else begin
      ro_load <= 1'b0;
      if (cs_rise) burst <= 1'b0;
      if (take) begin
        if (is_cmd) begin
          rd_active <= 1'b0;
          if (frame == CMD_ARM)    armed <= 1'b1;
          if (frame == CMD_DISARM) armed <= 1'b0;
          if (frame == CMD_BURST && armed && cfg_valid && cur_mode == M_SLIC) begin
            burst   <= 1'b1;
            ro_load <= 1'b1;
            ro_val  <= stat_byte(ch_cfg);
          end
        end else if (frame[FW-1]) begin
          cfg       <= frame[DATA_W-1:0];
          cfg_valid <= 1'b1;
          rd_active <= !armed && (new_mode == M_SLIC);
          ro_load   <= 1'b1;
          ro_val    <= stat_byte(ch_new);
        end else begin
          cfg_valid <= 1'b0;
          rd_active <= 1'b0;
        end
      end
      dout_oe <= cs_low && (rd_active || burst);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < CH; i++) begin
        ts_m[i]   <= '0;
        slic_m[i] <= '0;
        gm_m[i]   <= '0;
        gl_m[i]   <= '0;
      end
    end else if (take && !is_cmd && !frame[FW-1] && cfg_valid) begin
      case (cur_mode)
        M_CODEC: ts_m[ch_cfg]   <= frame[DATA_W-1:0];
        M_SLIC:  slic_m[ch_cfg] <= frame[DATA_W-1:0];
        M_GAIN:  if (cfg[0]) gm_m[ch_cfg] <= frame[DATA_W-1:0];
                 else        gl_m[ch_cfg] <= frame[DATA_W-1:0];
        default: ;
      endcase
    end
  end

  assign ro_shift = burst ? (sck_rise && cs_low)
                          : (rd_active && sck_fall && mid_frame && cs_low);
  assign cfg_o = cfg;

  for (genvar g = 0; g < CH; g++) begin : g_flat
    assign ts_o[g*DATA_W +: DATA_W]   = ts_m[g];
    assign slic_o[g*DATA_W +: DATA_W] = slic_m[g];
    assign gmsb_o[g*DATA_W +: DATA_W] = gm_m[g];
    assign glsb_o[g*DATA_W +: DATA_W] = gl_m[g];
  end
endmodule

// File: rtl/scp_ctrl_port.sv
module scp_ctrl_port #(
  parameter int CH_W        = 2,
  parameter int DATA_W      = 7,
  parameter int STAT_W      = 5,
  parameter int SYNC_STAGES = 2,
  localparam int CH         = 1 << CH_W,
  localparam int FW         = DATA_W + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sclk,
  input  logic                 cs_n,
  input  logic                 din,
  input  logic [CH*STAT_W-1:0] slic_status,
  output logic                 dout,
  output logic                 dout_oe,
  output logic [CH*DATA_W-1:0] time_slot,
  output logic [CH*DATA_W-1:0] slic_ctrl,
  output logic [CH*DATA_W-1:0] gain_msb,
  output logic [CH*DATA_W-1:0] gain_lsb
);
  logic sck_rise, sck_fall, cs_low, cs_rise, din_s;
  logic frame_valid, mid_frame;
  logic [FW-1:0] frame_byte;
  logic ro_load, ro_shift;
  logic [FW-1:0] ro_val;
  logic [DATA_W-1:0] cfg_q;

  scp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .din(din),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_low(cs_low),
    .cs_rise(cs_rise), .din_s(din_s)
  );

  scp_shifter #(.FW(FW)) u_shift (
    .clk(clk), .rst(rst), .sck_rise(sck_rise), .cs_low(cs_low), .din_s(din_s),
    .frame_valid(frame_valid), .frame(frame_byte), .mid_frame(mid_frame)
  );

  scp_regs #(.CH_W(CH_W), .DATA_W(DATA_W), .STAT_W(STAT_W)) u_regs (
    .clk(clk), .rst(rst), .frame_valid(frame_valid), .frame(frame_byte),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .mid_frame(mid_frame),
    .cs_low(cs_low), .cs_rise(cs_rise), .status(slic_status),
    .ro_load(ro_load), .ro_val(ro_val), .ro_shift(ro_shift),
    .dout_oe(dout_oe), .cfg_o(cfg_q),
    .ts_o(time_slot), .slic_o(slic_ctrl), .gmsb_o(gain_msb), .glsb_o(gain_lsb)
  );

  scp_readout #(.FW(FW)) u_ro (
    .clk(clk), .rst(rst), .load(ro_load), .load_val(ro_val),
    .shift(ro_shift), .dout(dout)
  );
endmodule

// File: rtl/scp_ctrl_port_chk.sv
module scp_ctrl_port_chk #(
  parameter int W  = 28,
  parameter int FW = 8,
  parameter int DW = 7
) (
  input logic          clk,
  input logic          rst,
  input logic          cs_low,
  input logic          dout_oe,
  input logic          frame_valid,
  input logic [FW-1:0] frame_byte,
  input logic [DW-1:0] cfg_q,
  input logic [W-1:0]  time_slot,
  input logic [W-1:0]  slic_ctrl,
  input logic [W-1:0]  gain_msb,
  input logic [W-1:0]  gain_lsb
);
  logic cmd_seen;
  assign cmd_seen = frame_valid &&
                    (frame_byte == 8'hFE || frame_byte == 8'hFF || frame_byte == 8'hFD);

  a_r7_cmd_keeps_cfg: assert property (@(posedge clk) disable iff (rst)
    cmd_seen |=> $stable(cfg_q));

  a_r9_oe_needs_cs: assert property (@(posedge clk) disable iff (rst)
    !cs_low |=> !dout_oe);

  a_r4_gain_halves_apart: assert property (@(posedge clk) disable iff (rst)
    !(!$stable(gain_msb) && !$stable(gain_lsb)));

  a_r5_one_group_per_cycle: assert property (@(posedge clk) disable iff (rst)
    $countones({!$stable(time_slot), !$stable(slic_ctrl),
                !$stable(gain_msb), !$stable(gain_lsb)}) <= 1);

  a_r2_write_after_frame: assert property (@(posedge clk) disable iff (rst)
    (!$stable(time_slot) || !$stable(slic_ctrl) || !$stable(gain_msb) || !$stable(gain_lsb))
      |-> $past(frame_valid));
endmodule

bind scp_ctrl_port scp_ctrl_port_chk #(.W(CH*DATA_W), .FW(FW), .DW(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .cs_low(cs_low), .dout_oe(dout_oe),
  .frame_valid(frame_valid), .frame_byte(frame_byte), .cfg_q(cfg_q),
  .time_slot(time_slot), .slic_ctrl(slic_ctrl),
  .gain_msb(gain_msb), .gain_lsb(gain_lsb)
);

// File: tb/tb_scp_ctrl_port.sv
`timescale 1ns/1ps
module tb_scp_ctrl_port;
  localparam int HALF = 6;

  logic clk = 1'b0, rst = 1'b1, sclk = 1'b0, cs_n = 1'b1, din = 1'b0;
  logic [19:0] st;
  logic dout, dout_oe;
  logic [27:0] time_slot, slic_ctrl, gain_msb, gain_lsb;

  scp_ctrl_port dut (
    .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .din(din),
    .slic_status(st), .dout(dout), .dout_oe(dout_oe),
    .time_slot(time_slot), .slic_ctrl(slic_ctrl),
    .gain_msb(gain_msb), .gain_lsb(gain_lsb)
  );

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] rx;
  logic oe_any, oe_all;
  logic [6:0] e_ts[4], e_sc[4], e_gm[4], e_gl[4];

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] b, input bit keep);
    cs_n = 1'b0;
    tick(4);
    oe_any = 1'b0;
    oe_all = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      din = b[i];
      tick(HALF);
      rx[i]  = dout;
      oe_any = oe_any | dout_oe;
      oe_all = oe_all & dout_oe;
      sclk = 1'b1;
      tick(HALF);
      sclk = 1'b0;
    end
    tick(4);
    if (!keep) begin
      cs_n = 1'b1;
      tick(6);
    end
  endtask

  task automatic cmp_all(input string req);
    for (int c = 0; c < 4; c++) begin
      chk(req, time_slot[c*7 +: 7], e_ts[c]);
      chk(req, slic_ctrl[c*7 +: 7], e_sc[c]);
      chk(req, gain_msb[c*7 +: 7],  e_gm[c]);
      chk(req, gain_lsb[c*7 +: 7],  e_gl[c]);
    end
  endtask

  function automatic logic [7:0] sbyte(input int c);
    return {st[c*5 +: 5], 3'b000};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 4; c++) begin
      e_ts[c] = '0; e_sc[c] = '0; e_gm[c] = '0; e_gl[c] = '0;
      st[c*5 +: 5] = 5'(c*7 + 3);
    end
    tick(5);
    rst = 1'b0;
    tick(10);

    // R1 reset state
    cmp_all("R1");
    chk("R1 oe", dout_oe, 0);

    // R2 codec mode sweep, R9 no drive during codec writes
    for (int c = 0; c < 4; c++) begin
      logic [6:0] d;
      d = 7'(c*29 + 5);
      xfer({4'b1000, 2'(c), 2'b00}, 0);
      xfer({1'b0, d}, 0);
      chk("R9 codec oe", oe_any, 0);
      e_ts[c] = d;
    end
    cmp_all("R2");

    // R3 line-interface mode with simultaneous status read
    for (int c = 0; c < 4; c++) begin
      logic [6:0] d;
      d = 7'(8'h40 | (c*11));
      xfer({4'b1101, 2'(c), 2'b00}, 0);
      xfer({1'b0, d}, 0);
      chk("R3 status", rx, sbyte(c));
      chk("R3 oe", oe_all, 1);
      e_sc[c] = d;
    end
    cmp_all("R3");
    chk("R9 idle oe", dout_oe, 0);

    // R4 gain halves
    for (int c = 0; c < 4; c++) begin
      logic [6:0] dm, dl;
      dm = 7'(c*19 + 1);
      dl = 7'(c*13 + 100);
      xfer({4'b1100, 2'(c), 2'b01}, 0);
      xfer({1'b0, dm}, 0);
      e_gm[c] = dm;
      xfer({4'b1100, 2'(c), 2'b00}, 0);
      xfer({1'b0, dl}, 0);
      e_gl[c] = dl;
    end
    cmp_all("R4");

    // R5 data without configuration, reserved mode
    xfer(8'h2A, 0);
    cmp_all("R5 no cfg");
    xfer({4'b1110, 2'b01, 2'b00}, 0);
    xfer(8'h33, 0);
    cmp_all("R5 reserved");

    // R6 partial frame discarded
    xfer({4'b1000, 2'b00, 2'b00}, 0);
    cs_n = 1'b0;
    tick(4);
    for (int i = 0; i < 3; i++) begin
      din = (i != 0);
      tick(HALF); sclk = 1'b1; tick(HALF); sclk = 1'b0;
    end
    tick(4);
    cs_n = 1'b1;
    tick(6);
    xfer(8'h0A, 0);
    e_ts[0] = 7'h0A;
    cmp_all("R6");

    // R7 commands keep configuration, unarmed burst command ignored
    xfer({4'b1000, 2'b01, 2'b00}, 0);
    xfer(8'hFE, 0);
    xfer(8'hFD, 0);
    xfer(8'h11, 0);
    e_ts[1] = 7'h11;
    cmp_all("R7 cfg kept");
    xfer({4'b1101, 2'b11, 2'b00}, 0);
    xfer(8'hFF, 1);
    xfer(8'h00, 0);
    chk("R7 no burst oe", oe_any, 0);
    e_sc[3] = 7'h00;
    cmp_all("R7");

    // R8 armed burst readout
    xfer(8'hFE, 0);
    xfer({4'b1101, 2'b10, 2'b00}, 0);
    xfer(8'hFF, 1);
    xfer(8'h00, 1);
    chk("R8 burst byte 1", rx, sbyte(2));
    chk("R8 burst oe", oe_all, 1);
    xfer(8'h5A, 0);
    chk("R8 burst byte 2", rx, sbyte(2));
    chk("R8 oe after cs", dout_oe, 0);
    cmp_all("R8 no write");
    xfer(8'hFD, 0);
    xfer(8'hFF, 1);
    xfer(8'h05, 0);
    chk("R8 disarmed oe", oe_any, 0);
    e_sc[2] = 7'h05;
    cmp_all("R8");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule